// File: doc/BRIEF.md
# Phase-Accumulator PWM Channel Bank

This block generates one or more pulse-width modulated outputs. Each channel has a single 32-bit control word that software reaches through a plain read/write port. The output frequency comes from an N-bit phase accumulator: on every clock the accumulator adds a programmable increment (the base value) and wraps modulo 2^N. The output frequency is therefore f_clk × base / 2^N. An 8-bit divisor with inverted sense sets the duty cycle. The output is high while the top eight accumulator bits are below 255 − divisor.

Software writes new base and divisor values into a staged copy and sets the update-request bit. The running copy loads those values only at the next accumulator wrap. A frequency or duty change therefore never cuts a period short. The request bit reads back as 1 until the load has happened. An enable bit gates the output. Each channel occupies its own 0x400-byte address window.

Top module: `pwm_phase_ctrl`

## Requirements
- R1: After reset every control word reads 0x0000_0000 and every output is low.
- R2: Control word layout: bit 31 is enable, bit 30 is update request, bits 8+N-1:8 hold the base value and bits 7:0 hold the divisor. Bits 29:8+N read 0, and writes to them have no effect.
- R3: Channel c sits at byte address c×0x400. An access whose offset inside a window is not zero changes nothing and reads 0.
- R4: While the channel is enabled, its accumulator adds the running base value every cycle, modulo 2^N. A period lasts 2^N / base cycles.
- R5: The output is high exactly while the top 8 accumulator bits are less than 255 − divisor. Divisor 255 keeps the output low. Divisor 0 keeps it high for 255 of 256 phase steps.
- R6: Staged base and divisor values move into the running copy only on a cycle where an update is pending and the accumulator wraps. Until then the output follows the old values.
- R7: The update-request bit reads 1 from the write that sets it until the running copy has loaded. After that it reads 0.
- R8: Writing enable = 0 drives the output low from the next cycle and returns the accumulator to zero. While a channel is disabled, a pending update loads on the next clock.
- R9: A running base value of zero freezes the accumulator and the output level. A pending update then loads on the next clock.
- R10: Channels are independent: writing one channel's word changes no other channel's word or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte address, shared by reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | NCH | One PWM output per channel |

## Verification
A running copy that loads too early shows up as a duty change inside the period in which it was requested. A copy that never loads shows up as an update bit stuck at 1 on readback. Both are visible within one period. An accumulator fault changes the number of high cycles counted over whole periods. The bench measures that count from a known zero phase, so a fault shows up within a few hundred cycles. A wrong frozen state shows up as a level change while the base value is zero.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;
  localparam int EN_BIT   = 31;
  localparam int UPD_BIT  = 30;
  localparam int BASE_LSB = 8;
  localparam int DIV_W    = 8;
  localparam int WIN_BITS = 10;
  localparam int MAX_BU_W = 22;

  // high phase: top phase bits below the inverted divisor
  function automatic logic duty_high(input logic [7:0] top, input logic [7:0] div);
    return top < (8'hFF - div);
  endfunction

  function automatic logic [31:0] pack_word(input logic en, input logic pend,
                                            input logic [MAX_BU_W-1:0] bu,
                                            input logic [DIV_W-1:0] div);
    return {en, pend, bu, div};
  endfunction
endpackage

// File: rtl/pwm_stage_reg.sv
module pwm_stage_reg #(
  parameter int BU_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            wr_en,
  input  logic            wr_upd,
  input  logic [BU_W-1:0] wr_bu,
  input  logic [7:0]      wr_div,
  input  logic            apply,
  output logic            en_q,
  output logic            pend_q,
  output logic [BU_W-1:0] bu_q,
  output logic [7:0]      div_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      bu_q   <= '0;
      div_q  <= '0;
    end else if (wr) begin
      en_q   <= wr_en;
      bu_q   <= wr_bu;
      div_q  <= wr_div;
    end
  end

  // a new request wins over a load in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend_q <= 1'b0;
    else if (wr && wr_upd)     pend_q <= 1'b1;
    else if (apply)            pend_q <= 1'b0;
  end
endmodule

// File: rtl/pwm_phase_core.sv
module pwm_phase_core
  import pwm_phase_pkg::*;
#(
  parameter int BU_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            pend,
  input  logic [BU_W-1:0] st_bu,
  input  logic [7:0]      st_div,
  output logic            apply,
  output logic [BU_W-1:0] wbu,
  output logic [7:0]      wdiv,
  output logic            pwm
);
  logic [BU_W-1:0] acc_q;
  logic [BU_W:0]   sum;
  logic            wrap;
  logic            idle;

  assign sum   = {1'b0, acc_q} + {1'b0, wbu};
  assign wrap  = en & sum[BU_W];
  assign idle  = !en || (wbu == '0);
  assign apply = pend & (wrap | idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (!en) acc_q <= '0;
    else          acc_q <= sum[BU_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbu  <= '0;
      wdiv <= '0;
    end else if (apply) begin
      wbu  <= st_bu;
      wdiv <= st_div;
    end
  end

  assign pwm = en & duty_high(acc_q[BU_W-1 -: 8], wdiv);
endmodule

// File: rtl/pwm_phase_ctrl.sv
module pwm_phase_ctrl
  import pwm_phase_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int BU_W   = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_o
);
  localparam int SEL_W = ADDR_W - WIN_BITS;

  if (BU_W < 8 || BU_W > MAX_BU_W) begin : g_bad_bu
    $error("BU_W out of range");
  end
  if (SEL_W < 1 || NCH > (1 << SEL_W)) begin : g_bad_addr
    $error("ADDR_W too small for NCH");
  end

  logic [SEL_W-1:0]          sel;
  logic                      off_zero;
  logic [NCH-1:0]            ch_wr;
  logic [NCH-1:0]            ch_en;
  logic [NCH-1:0]            ch_pend;
  logic [NCH-1:0]            ch_apply;
  logic [NCH-1:0][BU_W-1:0]  ch_sbu;
  logic [NCH-1:0][7:0]       ch_sdiv;
  logic [NCH-1:0][BU_W-1:0]  ch_wbu;
  logic [NCH-1:0][7:0]       ch_wdiv;
  logic [NCH-1:0][31:0]      ch_word;
  wire                       unused_wbits = ^bus_wdata[29:BASE_LSB+BU_W-1];

  assign sel      = bus_addr[ADDR_W-1:WIN_BITS];
  assign off_zero = (bus_addr[WIN_BITS-1:0] == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_wr[c] = bus_we && off_zero && (sel == SEL_W'(c));

    pwm_stage_reg #(.BU_W(BU_W)) stage_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (ch_wr[c]),
      .wr_en  (bus_wdata[EN_BIT]),
      .wr_upd (bus_wdata[UPD_BIT]),
      .wr_bu  (bus_wdata[BASE_LSB +: BU_W]),
      .wr_div (bus_wdata[DIV_W-1:0]),
      .apply  (ch_apply[c]),
      .en_q   (ch_en[c]),
      .pend_q (ch_pend[c]),
      .bu_q   (ch_sbu[c]),
      .div_q  (ch_sdiv[c])
    );

    pwm_phase_core #(.BU_W(BU_W)) core_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ch_en[c]),
      .pend   (ch_pend[c]),
      .st_bu  (ch_sbu[c]),
      .st_div (ch_sdiv[c]),
      .apply  (ch_apply[c]),
      .wbu    (ch_wbu[c]),
      .wdiv   (ch_wdiv[c]),
      .pwm    (pwm_o[c])
    );

    assign ch_word[c] = pack_word(ch_en[c], ch_pend[c],
                                  MAX_BU_W'(ch_sbu[c]), ch_sdiv[c]);
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (off_zero && sel == SEL_W'(c)) bus_rdata = ch_word[c];
    end
  end
endmodule

// File: rtl/pwm_phase_ctrl_chk.sv
module pwm_phase_ctrl_chk #(
  parameter int NCH  = 4,
  parameter int BU_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [31:0]              bus_wdata,
  input logic [31:0]              bus_rdata,
  input logic [NCH-1:0]           pwm_o,
  input logic [NCH-1:0]           ch_wr,
  input logic [NCH-1:0]           ch_en,
  input logic [NCH-1:0]           ch_pend,
  input logic [NCH-1:0]           ch_apply,
  input logic [NCH-1:0][BU_W-1:0] ch_wbu,
  input logic [NCH-1:0][7:0]      ch_wdiv
);
  localparam logic [31:0] USED = 32'hC000_0000 | ((32'd1 << (8 + BU_W)) - 32'd1);

  // R2
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~USED) == 32'd0);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R8
    dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_wr[c] && !bus_wdata[31]) |=> !pwm_o[c]);
    // R6
    apply_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_apply[c] |-> ch_pend[c]);
    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_apply[c] && !(ch_wr[c] && bus_wdata[30])) |=> !ch_pend[c]);
    // R6
    work_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_apply[c] |=> ($stable(ch_wbu[c]) && $stable(ch_wdiv[c])));
    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[c] && ch_wbu[c] == '0 && !ch_apply[c] && !ch_wr[c]) |=> $stable(pwm_o[c]));
    // R5
    div_max_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_wdiv[c] == 8'hFF) |-> !pwm_o[c]);
  end
endmodule

bind pwm_phase_ctrl pwm_phase_ctrl_chk #(.NCH(NCH), .BU_W(BU_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pwm_o     (pwm_o),
  .ch_wr     (ch_wr),
  .ch_en     (ch_en),
  .ch_pend   (ch_pend),
  .ch_apply  (ch_apply),
  .ch_wbu    (ch_wbu),
  .ch_wdiv   (ch_wdiv)
);

// File: tb/pwm_phase_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwm_phase_ctrl_tb_top;
  localparam int NCH = 4;
  localparam int AW  = 12;
  localparam int NROW = 6;
  // rows: base value, divisor, expected high cycles in 1024 cycles from phase 0
  localparam int ROW_BU  [NROW] = '{256, 256, 256, 512, 1024, 128};
  localparam int ROW_DIV [NROW] = '{0,   255, 127, 55,  200,  155};
  localparam int ROW_EXP [NROW] = '{1020, 0,  512, 800, 224,  400};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NCH-1:0] pwm_o;
  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  pwm_phase_ctrl #(.NCH(NCH), .BU_W(16), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // load values while disabled, then enable; returns with phase 0 on the output
  task automatic setup0(input int bu, input int dv);
    wr(12'h000, 32'h4000_0000 | (bu << 8) | dv);
    wr(12'h000, 32'h8000_0000 | (bu << 8) | dv);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int cnt;
    step(3);
    // R1 reset state
    rd(12'h000, d); check("R1 word ch0", d, 32'h0);
    rd(12'hC00, d); check("R1 word ch3", d, 32'h0);
    check("R1 outputs", 32'(pwm_o), 32'h0);
    rst_n = 1'b1;
    step(4);
    check("R1 outputs after release", 32'(pwm_o), 32'h0);

    // R4 R5 table of base/divisor pairs
    for (int r = 0; r < NROW; r++) begin
      setup0(ROW_BU[r], ROW_DIV[r]);
      cnt = 0;
      for (int k = 0; k < 1024; k++) begin
        cnt += int'(pwm_o[0]);
        @(negedge clk);
      end
      check($sformatf("R4/R5 row %0d high count", r), 32'(cnt), 32'(ROW_EXP[r]));
    end

    // R6 R7 deferred update, base 256 -> phase step k has top bits = k mod 256
    setup0(256, 0);
    step(50);
    wr(12'h000, 32'hC001_00FF);               // written at k=51, now k=52
    rd(12'h000, d); check("R7 pending visible", d, 32'hC001_00FF);
    check("R6 old duty kept", 32'(pwm_o[0]), 32'h1);
    step(202);                                // k=254
    check("R6 old duty at end of period", 32'(pwm_o[0]), 32'h1);
    rd(12'h000, d); check("R7 still pending", d, 32'hC001_00FF);
    step(2);                                  // k=256, new period
    check("R6 new duty after wrap", 32'(pwm_o[0]), 32'h0);
    rd(12'h000, d); check("R7 cleared after load", d, 32'h8001_00FF);

    // R9 freeze with zero base
    wr(12'h000, 32'hC000_0000);               // k=258
    step(254);                                // k=512, loaded at wrap
    check("R9 level after zero base load", 32'(pwm_o[0]), 32'h1);
    rd(12'h000, d); check("R9 word after load", d, 32'h8000_0000);
    step(100);
    check("R9 frozen level", 32'(pwm_o[0]), 32'h1);
    wr(12'h000, 32'hC000_00FF);
    rd(12'h000, d); check("R9 pending while frozen", d, 32'hC000_00FF);
    step(1);
    check("R9 update leaves freeze", 32'(pwm_o[0]), 32'h0);
    rd(12'h000, d); check("R9 loaded next clock", d, 32'h8000_00FF);

    // R3 non-zero offset ignored
    setup0(256, 0);
    wr(12'h004, 32'h0000_0000);
    rd(12'h004, d); check("R3 offset reads zero", d, 32'h0);
    rd(12'h000, d); check("R3 word unchanged", d, 32'h8001_0000);
    check("R3 output unchanged", 32'(pwm_o[0]), 32'h1);

    // R8 disable
    wr(12'h000, 32'h0001_0000);
    check("R8 low after disable", 32'(pwm_o[0]), 32'h0);
    step(3);
    check("R8 stays low", 32'(pwm_o[0]), 32'h0);
    rd(12'h000, d); check("R8 word", d, 32'h0001_0000);

    // R10 R2 other channels
    wr(12'h800, 32'hC012_3456);
    rd(12'h800, d); check("R10 ch2 staged", d, 32'hC012_3456);
    rd(12'h000, d); check("R10 ch0 untouched", d, 32'h0001_0000);
    check("R10 ch0 output untouched", 32'(pwm_o[0]), 32'h0);
    step(1);
    rd(12'h800, d); check("R9 ch2 loads from zero base", d, 32'h8012_3456);
    wr(12'hC00, 32'hFFFF_FFFF);
    rd(12'hC00, d); check("R2 unused bits read zero", d, 32'hC0FF_FFFF);
    step(1);
    rd(12'hC00, d); check("R2 ch3 after load", d, 32'h80FF_FFFF);
    check("R5 divisor 255 keeps ch3 low", 32'(pwm_o[3]), 32'h0);

    finish_run();
  end
endmodule